// File: doc/BRIEF.md
# Selectable Fuzzy Aggregation Operator

This unit merges two unsigned membership degrees into a single degree. A degree is a fixed-point fraction of width `W`. Zero stands for 0, and the all-ones word stands for 1. A 3-bit select picks one of six combining functions:

- minimum
- maximum
- bounded sum, which clips at one
- bounded difference, which clips at zero
- bounded product, which is a + b − 1 clipped at zero
- algebraic product, which is the rounded a·b scaled back to `W` bits

The select is captured in the same clock edge as the operands, so each input item carries its own operator. The result is registered. A valid pulse comes out exactly one clock after the valid pulse that went in. To reduce a longer list of degrees, feed each result back as an operand of the next item, or chain several units.

The two select codes with no function return zero and raise an error flag for that one item.

Top module: `fuzz_agg_op`

## Requirements
- R1: While reset is held, and after its release until the first valid item, `out_valid`, `op_err` and `result` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier, with exactly one output per accepted item.
- R3: Select 3'b000 gives min(a, b).
- R4: Select 3'b001 gives max(a, b).
- R5: Select 3'b010 gives a + b, saturated at the all-ones value.
- R6: Select 3'b011 gives a − b, or zero when b > a.
- R7: Select 3'b100 gives a + b − (2^W−1), or zero when that would be negative.
- R8: Select 3'b101 gives a·b/(2^W−1) rounded to nearest (half up), so an all-ones operand returns the other operand unchanged.
- R9: Selects 3'b110 and 3'b111 give a zero result with `op_err` high for that item's single output cycle. `op_err` is low on every other cycle.
- R10: When `in_valid` is low, `result` holds its last value whatever `op_sel`, `deg_a` and `deg_b` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 3 | Operator code, sampled with the operands |
| deg_a | input | W | First membership degree |
| deg_b | input | W | Second membership degree |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | W | Combined degree |
| op_err | output | 1 | The item used an unsupported code |

## Verification
The only state in the unit is the output register and the valid/error flags. Any fault in it shows on the very next cycle:
- a wrong value in `result`
- a valid pulse that is missing or extra
- an error flag on a legal code

A wrong operator decode, or an off-by-one in saturation or rounding, shows only for certain operand pairs. For that reason the operand set includes 0, 1, the midpoint pair and all-ones under every code. Hold behaviour is observed by idling the valid input while the other inputs toggle.

// File: rtl/fuzz_agg_op.sv
module fuzz_agg_op #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] deg_a,
  input  logic [W-1:0] deg_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         op_err
);
  localparam logic [W-1:0] ONE  = {W{1'b1}};
  localparam logic [2*W:0] HALF = (2*W+1)'(1) << (W-1);

  logic [W:0]     sum;
  logic [W:0]     over;
  logic [2*W-1:0] prod;
  logic [2*W:0]   biased;
  logic [2*W:0]   rnd;
  logic [W-1:0]   v_min, v_max, v_bsum, v_bdiff, v_bprod, v_alg, nxt;
  logic           bad;

  assign sum     = {1'b0, deg_a} + {1'b0, deg_b};
  assign over    = sum - {1'b0, ONE};
  assign prod    = deg_a * deg_b;
  assign biased  = {1'b0, prod} + HALF;
  assign rnd     = biased + (biased >> W);

  assign v_min   = (deg_a < deg_b) ? deg_a : deg_b;
  assign v_max   = (deg_a < deg_b) ? deg_b : deg_a;
  assign v_bsum  = sum[W] ? ONE : sum[W-1:0];
  assign v_bdiff = (deg_a > deg_b) ? deg_a - deg_b : '0;
  assign v_bprod = (sum > {1'b0, ONE}) ? over[W-1:0] : '0;
  assign v_alg   = rnd[2*W-1:W];
  assign bad     = op_sel[2] & op_sel[1];

  always_comb begin
    case (op_sel)
      3'b000:  nxt = v_min;
      3'b001:  nxt = v_max;
      3'b010:  nxt = v_bsum;
      3'b011:  nxt = v_bdiff;
      3'b100:  nxt = v_bprod;
      3'b101:  nxt = v_alg;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      op_err    <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      op_err    <= in_valid & bad;
      if (in_valid) result <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'b000) |=> (result <= $past(deg_a) && result <= $past(deg_b)));  // R3
  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'b001) |=> (result >= $past(deg_a) && result >= $past(deg_b)));  // R4
  AST_BSUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'b010) |=> (result >= $past(deg_a) && result >= $past(deg_b)));  // R5
  AST_BDIFF_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'b011) |=> (result <= $past(deg_a)));  // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (out_valid && result == '0));  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));  // R10
endmodule

// File: tb/test_fuzz_agg_op.sv
module test_fuzz_agg_op;
  localparam int W = 8;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op_sel = 3'b000;
  logic [W-1:0] deg_a = '0;
  logic [W-1:0] deg_b = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         op_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [W:0] q_exp[$];
  string      q_tag[$];
  logic [W-1:0] last_res = '0;

  always #2.5 clk = ~clk;

  fuzz_agg_op #(.W(W)) i_fuzz_agg_op (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .deg_a(deg_a), .deg_b(deg_b), .out_valid(out_valid),
    .result(result), .op_err(op_err)
  );

  function automatic logic [W:0] model(input int op, input int a, input int b);
    int r;
    bit e;
    e = 1'b0;
    case (op)
      0: r = (a < b) ? a : b;
      1: r = (a > b) ? a : b;
      2: r = (a + b > M) ? M : a + b;
      3: r = (a > b) ? a - b : 0;
      4: r = (a + b > M) ? a + b - M : 0;
      5: r = (2 * a * b + M) / (2 * M);
      default: begin r = 0; e = 1'b1; end
    endcase
    return {e, W'(r)};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int op, input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1;
    op_sel = 3'(op);
    deg_a = W'(a);
    deg_b = W'(b);
    q_exp.push_back(model(op, a, b));
    q_tag.push_back(tag_of(op));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_sel = 3'(k + 2);
      deg_a = W'(k * 37 + 11);
      deg_b = W'(k * 53 + 7);
    end
  endtask

  // Monitor: outputs change at posedge, sampled at negedge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          logic [W:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(result == e[W-1:0], t, int'(result), int'(e[W-1:0]));
          check(op_err == e[W], {t, " R9 err flag"}, int'(op_err), int'(e[W]));
        end
        last_res = result;
      end else begin
        check(op_err == 1'b0, "R9 err without valid", int'(op_err), 0);
        check(result == last_res, "R10 hold", int'(result), int'(last_res));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int pts[6] = '{0, 1, 127, 128, 200, 255};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(op_err == 1'b0, "R1 op_err in reset", int'(op_err), 0);
    check(result == '0, "R1 result in reset", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    check(result == '0, "R1 result after reset", int'(result), 0);

    drive(2, 200, 100);
    drive(3, 10, 20);
    drive(4, 128, 127);
    drive(4, 128, 128);
    drive(5, 255, 77);
    drive(5, 128, 128);
    drive(6, 255, 255);
    drive(0, 9, 3);
    idle(4);
    drive(7, 1, 1);
    idle(1);
    drive(1, 4, 250);
    idle(5);

    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          drive(op, pts[i], pts[j]);
          if (j == 5) idle(2);
        end
    idle(4);

    for (int s = 0; s < 60; s++) begin
      drive(s % 8, (s * 97 + 13) % 256, (s * 41 + 200) % 256);
      if (s % 7 == 0) idle(1);
    end
    idle(4);

    check(q_exp.size() == 0, "R2 outstanding items", q_exp.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule